// File: doc/BRIEF.md
# Triggered Burst-Averaging Sample Controller

This block sits between a conversion trigger source and a converter that produces samples. It turns each incoming trigger into conversion requests and hands back one result per trigger. When averaging is on, a trigger starts a burst of 4, 8, 16 or 32 conversions. The block issues them one at a time, each as soon as the previous one has returned. Their timing owes nothing to the trigger period, so averaged results still come out at the trigger rate.

The returned samples are summed. Once the final sample of the burst is in, the rounded mean is registered and a single completion pulse is raised. When averaging is off, a trigger causes exactly one conversion, and its sample is passed straight to the output with the same pulse.

The configuration is sampled at the trigger. A trigger that arrives while a burst is still running is dropped, and it sets a sticky overrun flag that only reset clears.

Top module: `burst_avg_ctrl`

## Requirements
- R1: With averaging on, `avg_sel_i` picks the burst length per trigger: 0 gives 4 conversions, 1 gives 8, 2 gives 16 and 3 gives 32.
- R2: With averaging off, a trigger issues exactly one conversion request, and `result_o` equals that sample unchanged.
- R3: With averaging on, `result_o` equals (sum + N/2) >> log2(N), where N is the burst length. This is the mean rounded half up, so a mean of exactly x.5 yields x+1.
- R4: `done_o` is high for exactly one cycle per accepted trigger, only after the last sample of the burst has returned, and never for intermediate samples.
- R5: `conv_req_o` is a one-cycle pulse. No new request is issued until `conv_valid_i` has answered the previous one.
- R6: A trigger seen while a burst is in progress starts no extra conversion and leaves the running result unaffected. It sets `overrun_o`, which then stays high until reset. Without such a trigger, `overrun_o` stays low.
- R7: Changes to `avg_en_i` or `avg_sel_i` during a burst do not alter that burst. The new values apply from the next accepted trigger.
- R8: During and right after reset, `conv_req_o`, `done_o` and `overrun_o` are low and `result_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Conversion trigger, one-cycle pulse |
| avg_en_i | input | 1 | Averaging enable, sampled at trigger |
| avg_sel_i | input | 2 | Burst length select, sampled at trigger |
| conv_req_o | output | 1 | Request for one conversion |
| conv_data_i | input | RES_W | Converter sample |
| conv_valid_i | input | 1 | Sample valid strobe |
| result_o | output | RES_W | Averaged or passed-through result |
| done_o | output | 1 | Result ready, one-cycle pulse |
| overrun_o | output | 1 | Sticky flag: trigger dropped while busy |

## Verification
The hardest case to reach is a second trigger that arrives in the middle of a long burst, together with a configuration change at the same moment. The bench starts a 32-sample burst and, a few cycles in, flips both the enable and the select and fires another trigger. It then checks that the burst still ran 32 conversions, that the mean matches, that only one completion appeared and that the overrun flag is set. Exact half-LSB rounding and full-scale sums are reached with directed data patterns from the converter model, while random latencies vary the handshake timing.

// File: rtl/burst_avg_pkg.sv
package burst_avg_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_FIN
  } seq_state_t;

  // select 0..3 maps to a shift of 2..5 (4..32 samples)
  function automatic logic [2:0] sel_to_shift(input logic [1:0] sel);
    return 3'(sel) + 3'd2;
  endfunction

endpackage

// File: rtl/burst_seq.sv
module burst_seq
  import burst_avg_pkg::*;
#(
  parameter int MAX_SHIFT = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       trig_i,
  input  logic       avg_en_i,
  input  logic [1:0] avg_sel_i,
  input  logic       conv_valid_i,
  output logic       conv_req_o,
  output logic       acc_clr_o,
  output logic       acc_add_o,
  output logic       fin_o,
  output logic [2:0] shift_o,
  output logic       overrun_o
);

  localparam int CNT_W = MAX_SHIFT;

  seq_state_t       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [2:0]       shift_q;
  logic [CNT_W:0]   span;
  logic [CNT_W-1:0] last_cnt;
  logic             accept;

  assign span      = (CNT_W+1)'(1) << shift_q;
  assign last_cnt  = CNT_W'(span - 1'b1);
  assign accept    = (state_q == ST_IDLE) && trig_i;
  assign acc_clr_o = accept;
  assign acc_add_o = (state_q == ST_WAIT) && conv_valid_i;
  assign fin_o     = (state_q == ST_FIN);
  assign shift_o   = shift_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      shift_q    <= '0;
      conv_req_o <= 1'b0;
      overrun_o  <= 1'b0;
    end else begin
      conv_req_o <= 1'b0;
      if (trig_i && state_q != ST_IDLE) overrun_o <= 1'b1;
      case (state_q)
        ST_IDLE: begin
          if (trig_i) begin
            shift_q    <= avg_en_i ? sel_to_shift(avg_sel_i) : 3'd0;
            cnt_q      <= '0;
            conv_req_o <= 1'b1;
            state_q    <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (conv_valid_i) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == last_cnt) state_q <= ST_FIN;
            else conv_req_o <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/avg_accum.sv
module avg_accum #(
  parameter int RES_W     = 12,
  parameter int MAX_SHIFT = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             add_i,
  input  logic [RES_W-1:0] data_i,
  input  logic             fin_i,
  input  logic [2:0]       shift_i,
  output logic [RES_W-1:0] result_o,
  output logic             done_o
);

  localparam int ACC_W = RES_W + MAX_SHIFT;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] half;
  logic [ACC_W-1:0] rounded;

  assign half    = (shift_i == 3'd0) ? '0 : (ACC_W'(1) << (shift_i - 3'd1));
  assign rounded = (acc_q + half) >> shift_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= '0;
      result_o <= '0;
      done_o   <= 1'b0;
    end else begin
      if (clr_i)      acc_q <= '0;
      else if (add_i) acc_q <= acc_q + ACC_W'(data_i);
      if (fin_i) result_o <= rounded[RES_W-1:0];
      done_o <= fin_i;
    end
  end

endmodule

// File: rtl/burst_avg_ctrl.sv
module burst_avg_ctrl #(
  parameter int RES_W     = 12,
  parameter int MAX_SHIFT = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig_i,
  input  logic             avg_en_i,
  input  logic [1:0]       avg_sel_i,
  output logic             conv_req_o,
  input  logic [RES_W-1:0] conv_data_i,
  input  logic             conv_valid_i,
  output logic [RES_W-1:0] result_o,
  output logic             done_o,
  output logic             overrun_o
);

  logic       acc_clr;
  logic       acc_add;
  logic       fin;
  logic [2:0] shift;

  burst_seq #(.MAX_SHIFT(MAX_SHIFT)) u_seq (
    .clk          (clk),
    .rst          (rst),
    .trig_i       (trig_i),
    .avg_en_i     (avg_en_i),
    .avg_sel_i    (avg_sel_i),
    .conv_valid_i (conv_valid_i),
    .conv_req_o   (conv_req_o),
    .acc_clr_o    (acc_clr),
    .acc_add_o    (acc_add),
    .fin_o        (fin),
    .shift_o      (shift),
    .overrun_o    (overrun_o)
  );

  avg_accum #(.RES_W(RES_W), .MAX_SHIFT(MAX_SHIFT)) u_acc (
    .clk      (clk),
    .rst      (rst),
    .clr_i    (acc_clr),
    .add_i    (acc_add),
    .data_i   (conv_data_i),
    .fin_i    (fin),
    .shift_i  (shift),
    .result_o (result_o),
    .done_o   (done_o)
  );

endmodule

// File: rtl/burst_avg_chk.sv
module burst_avg_chk (
  input logic clk,
  input logic rst,
  input logic trig_i,
  input logic conv_req_o,
  input logic conv_valid_i,
  input logic done_o,
  input logic overrun_o
);

  logic pend_q;

  always_ff @(posedge clk) begin
    if (rst)               pend_q <= 1'b0;
    else if (conv_valid_i) pend_q <= 1'b0;
    else if (conv_req_o)   pend_q <= 1'b1;
  end

  p_single_req_r5: assert property (@(posedge clk) disable iff (rst)
    conv_req_o |-> !pend_q);

  p_req_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    conv_req_o |=> !conv_req_o);

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_done_settled_r4: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!pend_q && !conv_req_o));

  p_overrun_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    overrun_o |=> overrun_o);

  p_overrun_cause_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun_o) |-> $past(trig_i));

endmodule

bind burst_avg_ctrl burst_avg_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .trig_i       (trig_i),
  .conv_req_o   (conv_req_o),
  .conv_valid_i (conv_valid_i),
  .done_o       (done_o),
  .overrun_o    (overrun_o)
);

// File: tb/sim_burst_avg_ctrl.sv
module sim_burst_avg_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int RES_W      = 12;
  localparam int MAXV       = (1 << RES_W) - 1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             trig = 1'b0;
  logic             avg_en = 1'b0;
  logic [1:0]       avg_sel = 2'd0;
  logic             conv_req;
  logic [RES_W-1:0] conv_data = '0;
  logic             conv_valid = 1'b0;
  logic [RES_W-1:0] result;
  logic             done;
  logic             overrun;

  int checks = 0;
  int errors = 0;
  int model_sum = 0;
  int model_cnt = 0;
  int data_mode = 0;
  int done_cnt = 0;
  int last_result = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_avg_ctrl #(.RES_W(RES_W)) u0 (
    .clk          (clk),
    .rst          (rst),
    .trig_i       (trig),
    .avg_en_i     (avg_en),
    .avg_sel_i    (avg_sel),
    .conv_req_o   (conv_req),
    .conv_data_i  (conv_data),
    .conv_valid_i (conv_valid),
    .result_o     (result),
    .done_o       (done),
    .overrun_o    (overrun)
  );

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_mean(input int sum, input int sh);
    if (sh == 0) return sum;
    return (sum + (1 << (sh - 1))) >> sh;
  endfunction

  function automatic int sample_value(input int idx);
    case (data_mode)
      1: return MAXV;
      2: return (idx == 0 || idx == 3) ? 1 : 0;
      3: return 0;
      default: return int'($urandom % (MAXV + 1));
    endcase
  endfunction

  // converter model: latency 1..3 cycles after each request
  initial begin
    @(negedge clk);
    forever begin
      while (!conv_req) @(negedge clk);
      repeat (1 + int'($urandom % 3)) @(negedge clk);
      conv_data  = RES_W'(sample_value(model_cnt));
      model_sum += int'(conv_data);
      model_cnt++;
      conv_valid = 1'b1;
      @(negedge clk);
      conv_valid = 1'b0;
    end
  end

  // completion monitor
  initial begin
    forever begin
      @(negedge clk);
      if (done) begin
        done_cnt++;
        last_result = int'(result);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_sim();
  end

  // disturb_at >= 0: flip config and re-trigger that many cycles in
  task automatic run_burst(input bit en, input logic [1:0] sel, input int disturb_at);
    int d0 = done_cnt;
    int n = en ? (4 << sel) : 1;
    int sh = en ? (int'(sel) + 2) : 0;
    int t = 0;
    model_sum = 0;
    model_cnt = 0;
    avg_en  = en;
    avg_sel = sel;
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    if (disturb_at >= 0) begin
      repeat (disturb_at) @(negedge clk);
      avg_en  = ~en;
      avg_sel = ~sel;
      trig = 1'b1;
      @(negedge clk);
      trig = 1'b0;
    end
    while (done_cnt == d0 && t < 2000) begin
      @(negedge clk);
      t++;
    end
    repeat (4) @(negedge clk);
    check(done_cnt == d0 + 1, "R4", "completions per trigger", done_cnt - d0, 1);
    check(model_cnt == n, en ? "R1" : "R2", "conversions issued", model_cnt, n);
    check(last_result == exp_mean(model_sum, sh), en ? "R3" : "R2", "result",
          last_result, exp_mean(model_sum, sh));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R8: reset state
    check(conv_req == 1'b0, "R8", "conv_req in reset", int'(conv_req), 0);
    check(done == 1'b0, "R8", "done in reset", int'(done), 0);
    check(overrun == 1'b0, "R8", "overrun in reset", int'(overrun), 0);
    rst = 1'b0;
    @(negedge clk);
    check(int'(result) == 0, "R8", "result after reset", int'(result), 0);

    // R1: every burst length with random data
    for (int s = 0; s < 4; s++) run_burst(1'b1, 2'(s), -1);
    // R2: pass-through
    run_burst(1'b0, 2'd2, -1);
    // R3: half-LSB tie rounds up (1,0,0,1 over 4 -> 1)
    data_mode = 2;
    run_burst(1'b1, 2'd0, -1);
    check(last_result == 1, "R3", "tie rounding", last_result, 1);
    // R3: full-scale sum over 32
    data_mode = 1;
    run_burst(1'b1, 2'd3, -1);
    check(last_result == MAXV, "R3", "full scale", last_result, MAXV);
    data_mode = 3;
    run_burst(1'b1, 2'd1, -1);
    check(last_result == 0, "R3", "zero data", last_result, 0);
    data_mode = 0;
    // R6: no overrun so far
    check(overrun == 1'b0, "R6", "overrun before busy trigger", int'(overrun), 0);

    // random mix
    for (int i = 0; i < 20; i++)
      run_burst(1'($urandom % 4 != 0), 2'($urandom % 4), -1);

    // R6/R7: re-trigger and config change mid-burst
    run_burst(1'b1, 2'd3, 5);
    check(overrun == 1'b1, "R6", "overrun after busy trigger", int'(overrun), 1);
    repeat (5) @(negedge clk);
    check(overrun == 1'b1, "R6", "overrun sticky", int'(overrun), 1);
    // R7: new config takes effect on next trigger
    run_burst(1'b0, 2'd0, -1);
    run_burst(1'b1, 2'd1, 3);

    // R8: reset clears overrun
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(overrun == 1'b0, "R8", "overrun cleared by reset", int'(overrun), 0);
    check(int'(result) == 0, "R8", "result cleared by reset", int'(result), 0);
    run_burst(1'b1, 2'd2, -1);

    finish_sim();
  end

endmodule